// File: doc/BRIEF.md
# Serial Receiver with Idle Timeout

This block turns an asynchronous serial line into bytes held in a small receive FIFO. It oversamples the line with an external sample tick (OVS ticks per bit), finds the start bit, samples every data, parity and stop bit near its centre, and pushes the assembled character into the FIFO. Word length, parity and stop-bit count are set by static configuration inputs. Rate generation and any bulk-transfer engine are outside the block.

Each finished character is checked for framing, parity and break conditions. One sticky flag per character is latched in the status word by fixed priority, and an overrun flag marks a character lost to a full FIFO. The status word also carries a FIFO-empty bit and a 16-bit running count of accepted characters. A receive event pulses for every accepted character.

An idle timer raises a timeout event when characters sit unread in the FIFO while the line has been quiet for a programmed number of bit times. This lets software or a transfer engine collect a short tail of data without waiting for a FIFO threshold.

Top module: `uart_rx_timeout`

## Requirements
- R1: A frame is a low start bit, then 5 to 8 data bits LSB first (`word_len_i` 0,1,2,3 selects 5,6,7,8 bits), then an optional parity bit, then one or two stop bits. The character goes into the FIFO with unused upper bits zero. `rd_data_o` shows the oldest entry, and `rd_i` removes it. A read of an empty FIFO is ignored.
- R2: With `parity_en_i` set, the parity bit must make the count of ones over data and parity even (`parity_even_i`=1) or odd (`parity_even_i`=0). A mismatch sets status bit 17.
- R3: A stop bit sampled low sets status bit 16. With `two_stop_i` set, both stop bits are checked. After a low stop bit the receiver waits for the line to go high before it looks for a new start bit.
- R4: A frame whose data, parity and stop bits are all zero is a break and sets status bit 18. Each character sets at most one of bits 18, 17 and 16, in that order of priority. The character (0x00) is still stored.
- R5: A character that completes while the FIFO holds DEPTH entries sets status bit 19 and is dropped. The FIFO contents stay unchanged.
- R6: A one-cycle `stat_clr_i` clears status bits 19:16. It leaves the count and the FIFO untouched.
- R7: Status bit 24 is 1 exactly when the FIFO is empty. Bits 15:0 count accepted characters, wrapping at 16 bits. `rx_irq_o` pulses for one cycle per accepted character, in the same cycle the count advances. All other status bits read 0.
- R8: Characters are received only while both `uart_en_i` and `rx_en_i` are 1. A frame sent while either is 0 leaves the FIFO, the count and the flags unchanged.
- R9: With `to_en_i` set and `to_limit_i` nonzero, `to_irq_o` pulses once after `to_limit_i` bit times with the FIFO non-empty, the receiver idle, and no read or new character. It does not pulse again until one of those restarts the timer. A limit of 0 never fires.
- R10: A read restarts the idle timer. No timeout is raised while the FIFO is empty.
- R11: After reset, the status word is 0x01000000 and both events are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| bit_tick_i | input | 1 | Sample tick, OVS ticks per bit |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Parity bit present |
| parity_even_i | input | 1 | 1 even parity, 0 odd |
| two_stop_i | input | 1 | Two stop bits |
| uart_en_i | input | 1 | Peripheral enable |
| rx_en_i | input | 1 | Receive enable |
| to_en_i | input | 1 | Idle timeout enable |
| to_limit_i | input | 11 | Idle timeout in bit times |
| rd_i | input | 1 | FIFO read strobe |
| stat_clr_i | input | 1 | Clear error flags |
| rd_data_o | output | 8 | Oldest FIFO entry |
| status_o | output | 32 | Flags, empty bit, received count |
| rx_irq_o | output | 1 | Character accepted pulse |
| to_irq_o | output | 1 | Idle timeout pulse |

## Verification
The bench targets the flag priority cases. A parity error on a frame with a bad stop bit must show only bit 17, and a break under odd parity must show only bit 18; a design with the priority wrong would light several flags. A break followed by a line held low must yield exactly one character, where a receiver that re-arms at once would store phantom breaks. The bench also sends a fifth character into a full four-entry FIFO, which catches a design that overwrites or miscounts. The timeout is measured in cycles from the last character and from a read, which exposes timers that fail to restart, that fire twice, or that fire on an empty FIFO or a zero limit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } rx_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_e;

  localparam int unsigned ST_FRM   = 16;
  localparam int unsigned ST_PAR   = 17;
  localparam int unsigned ST_BRK   = 18;
  localparam int unsigned ST_OVR   = 19;
  localparam int unsigned ST_EMPTY = 24;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  rx_cfg_t    cfg_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       brk_o
);
  localparam int unsigned SW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] SUB_MID  = SW'(OVS / 2 - 1);

  rx_state_e     state_q;
  logic [SW-1:0] sub_q;
  logic [3:0]    idx_q;
  logic [7:0]    shreg_q;
  logic          par_q, ferr_q, allz_q;
  logic [3:0]    nbits, last_idx;
  logic          exp_par;

  assign nbits    = 4'd5 + {2'b00, cfg_i.wlen};
  assign last_idx = nbits + {3'b000, cfg_i.par_en} + {3'b000, cfg_i.two_stop};
  assign exp_par  = cfg_i.par_even ? ^shreg_q : ~(^shreg_q);
  assign busy_o   = (state_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      ferr_q  <= 1'b0;
      allz_q  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (tick_i && !rx_i) begin
          state_q <= RX_START;
          sub_q   <= '0;
        end
        RX_START: if (tick_i) begin
          if (sub_q == SUB_MID) begin
            // confirm start at mid-bit, else treat as glitch
            state_q <= rx_i ? RX_IDLE : RX_BITS;
            sub_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            ferr_q  <= 1'b0;
            allz_q  <= 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        RX_BITS: if (tick_i) begin
          if (sub_q == SUB_LAST) begin
            sub_q  <= '0;
            idx_q  <= idx_q + 1'b1;
            allz_q <= allz_q & ~rx_i;
            if (idx_q < nbits) shreg_q[idx_q[2:0]] <= rx_i;
            else if (cfg_i.par_en && idx_q == nbits) par_q <= rx_i;
            else if (!rx_i) ferr_q <= 1'b1;
            if (idx_q == last_idx) begin
              done_o  <= 1'b1;
              data_o  <= shreg_q;
              ferr_o  <= ferr_q | ~rx_i;
              brk_o   <= allz_q & ~rx_i;
              perr_o  <= cfg_i.par_en & (par_q != exp_par);
              state_q <= rx_i ? RX_IDLE : RX_HOLD;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        RX_HOLD: if (rx_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assert_off_no_char_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_o);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wp_q, rp_q, lvl;

  assign lvl     = wp_q - rp_q;
  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign rdata_o = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
    end
  end

  assert_push_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_drain_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && lvl == (AW+1)'(1)) |=> empty_o);
endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer #(
  parameter int unsigned OVS  = 4,
  parameter int unsigned TO_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            restart_i,
  input  logic            nonempty_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            fire_o
);
  localparam int unsigned DW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(OVS - 1);

  logic [DW-1:0]   div_q;
  logic [TO_W-1:0] cnt_q;
  logic            armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (restart_i) begin
        div_q   <= '0;
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (tick_i) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (armed_q) begin
            if (limit_i != '0 && cnt_q == limit_i - 1'b1 && nonempty_i) begin
              fire_o  <= 1'b1;
              armed_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assert_fire_nonempty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(nonempty_i));
  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned OVS   = 4,
  parameter int unsigned TO_W  = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_i,
  input  logic            bit_tick_i,
  input  logic [1:0]      word_len_i,
  input  logic            parity_en_i,
  input  logic            parity_even_i,
  input  logic            two_stop_i,
  input  logic            uart_en_i,
  input  logic            rx_en_i,
  input  logic            to_en_i,
  input  logic [TO_W-1:0] to_limit_i,
  input  logic            rd_i,
  input  logic            stat_clr_i,
  output logic [7:0]      rd_data_o,
  output logic [31:0]     status_o,
  output logic            rx_irq_o,
  output logic            to_irq_o
);
  localparam int unsigned CNT_W = 16;  // fixed by status layout

  rx_cfg_t          cfg;
  logic             rx_on, busy, done, perr, ferr, brk;
  logic [7:0]       rx_byte;
  logic             fifo_empty, fifo_full, push, pop, restart;
  logic             frm_q, par_q, brk_q, ovr_q;
  logic [CNT_W-1:0] cnt_q;

  assign cfg   = '{wlen: word_len_i, par_en: parity_en_i,
                   par_even: parity_even_i, two_stop: two_stop_i};
  assign rx_on = uart_en_i & rx_en_i;
  assign push  = done & ~fifo_full;
  assign pop   = rd_i & ~fifo_empty;

  uart_rx_frame #(.OVS(OVS)) i_frame (
    .clk_i, .rst_ni, .en_i(rx_on), .tick_i(bit_tick_i), .rx_i, .cfg_i(cfg),
    .busy_o(busy), .done_o(done), .data_o(rx_byte),
    .perr_o(perr), .ferr_o(ferr), .brk_o(brk)
  );

  uart_rx_fifo #(.DW(8), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(rx_byte), .pop_i(pop),
    .rdata_o(rd_data_o), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  assign restart = done | pop | busy | fifo_empty | ~to_en_i;

  uart_rx_idle_timer #(.OVS(OVS), .TO_W(TO_W)) i_timer (
    .clk_i, .rst_ni, .tick_i(bit_tick_i), .restart_i(restart),
    .nonempty_i(~fifo_empty), .limit_i(to_limit_i), .fire_o(to_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q    <= 1'b0;
      par_q    <= 1'b0;
      brk_q    <= 1'b0;
      ovr_q    <= 1'b0;
      cnt_q    <= '0;
      rx_irq_o <= 1'b0;
    end else begin
      rx_irq_o <= push;
      if (push) cnt_q <= cnt_q + 1'b1;
      if (stat_clr_i) begin
        frm_q <= 1'b0;
        par_q <= 1'b0;
        brk_q <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (done) begin
        // one flag per character: break > parity > framing
        if (brk)       brk_q <= 1'b1;
        else if (perr) par_q <= 1'b1;
        else if (ferr) frm_q <= 1'b1;
        if (fifo_full) ovr_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[CNT_W-1:0] = cnt_q;
    status_o[ST_FRM]   = frm_q;
    status_o[ST_PAR]   = par_q;
    status_o[ST_BRK]   = brk_q;
    status_o[ST_OVR]   = ovr_q;
    status_o[ST_EMPTY] = fifo_empty;
  end

  assert_one_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({$rose(brk_q), $rose(par_q), $rose(frm_q)}) <= 1);
  assert_ovr_when_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(fifo_full));
  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> status_o[15:0] == $past(status_o[15:0]) + 16'd1);
  assert_clr_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !done) |=> status_o[19:16] == 4'h0);
endmodule

// File: tb/test_uart_rx_timeout.sv
module test_uart_rx_timeout;
  localparam int BIT_CLK = 8;  // 4 ticks per bit, one tick every 2 clocks
  localparam int TLIM    = 128;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx = 1'b1, tick = 1'b0;
  logic [1:0]  wlen = 2'd3;
  logic        pen = 1'b0, peven = 1'b0, stop2 = 1'b0;
  logic        uen = 1'b1, ren = 1'b1, toen = 1'b0;
  logic [10:0] tolim = '0;
  logic        rd = 1'b0, clr = 1'b0;
  logic [7:0]  rdata;
  logic [31:0] stat;
  logic        rxirq, toirq;

  always #5 clk = ~clk;

  uart_rx_timeout i_uart_rx_timeout (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .bit_tick_i(tick),
    .word_len_i(wlen), .parity_en_i(pen), .parity_even_i(peven),
    .two_stop_i(stop2), .uart_en_i(uen), .rx_en_i(ren), .to_en_i(toen),
    .to_limit_i(tolim), .rd_i(rd), .stat_clr_i(clr),
    .rd_data_o(rdata), .status_o(stat), .rx_irq_o(rxirq), .to_irq_o(toirq)
  );

  int n_chk = 0, n_bad = 0, irq_seen = 0, to_seen = 0, exp_cnt = 0;
  longint cyc = 0, rx_cyc = 0, to_cyc = 0, rd_cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    #1 tick = ~tick;
  end

  // monitor: scoreboard pop on each accepted read, event bookkeeping
  always @(negedge clk) begin
    cyc++;
    if (rd && !stat[24]) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected read data", {24'h0, rdata}, 32'h0);
      else begin
        exp_b = exp_q.pop_front();
        check(rdata === exp_b, "R1 read data", {24'h0, rdata}, {24'h0, exp_b});
      end
      rd_cyc = cyc;
    end
    if (rxirq) begin irq_seen++; rx_cyc = cyc; end
    if (toirq) begin to_seen++; to_cyc = cyc; end
  end

  initial begin
    repeat (120000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic send_bit(input logic b);
    rx = b;
    repeat (BIT_CLK) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(wlen);
    m = d & 8'((1 << nb) - 1);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(m[i]);
    if (pen) begin
      p = peven ? ^m : ~(^m);
      send_bit(p ^ bad_par);
    end
    if (stop2) send_bit(1'b1);
    send_bit(!bad_stop);
    send_bit(1'b1);
  endtask

  task automatic send_break(input int extra);
    int n;
    n = 1 + 5 + int'(wlen) + int'(pen) + 1 + int'(stop2) + extra;
    for (int i = 0; i < n; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic expect_char(input logic [7:0] d);
    exp_q.push_back(d);
    exp_cnt++;
  endtask

  task automatic read_one();
    @(posedge clk); #1 rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic drain(input string req);
    forever begin
      @(negedge clk);
      if (stat[24]) break;
      read_one();
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic clear_flags();
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
  endtask

  task automatic check_flags(input logic [3:0] e, input string req);
    @(negedge clk);
    check(stat[19:16] === e, req, {28'h0, stat[19:16]}, {28'h0, e});
  endtask

  task automatic check_count(input string req);
    @(negedge clk);
    check(stat[15:0] === 16'(exp_cnt) && irq_seen == exp_cnt, req,
          {16'h0, stat[15:0]}, 32'(exp_cnt));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stat === 32'h0100_0000 && !rxirq && !toirq, "R11 reset state", stat, 32'h0100_0000);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check(stat === 32'h0100_0000, "R11 after reset release", stat, 32'h0100_0000);

    // R1: 8N1, then 5 and 7 data bits
    expect_char(8'hA5); send_frame(8'hA5, 0, 0);
    expect_char(8'h3C); send_frame(8'h3C, 0, 0);
    check_count("R7 count after two chars");
    check(stat[24] === 1'b0, "R7 non-empty bit", stat, 32'h0);
    drain("R1 drain 8-bit");
    @(negedge clk);
    check(stat[24] === 1'b1, "R7 empty bit after drain", stat, 32'h0100_0000);
    read_one();  // read of empty FIFO is ignored
    wlen = 2'd0; expect_char(8'h1F); send_frame(8'hFF, 0, 0);
    wlen = 2'd2; expect_char(8'h5A); send_frame(8'h5A, 0, 0);
    drain("R1 drain short words");
    check_count("R1 count short words");
    check_flags(4'h0, "R1 no flags on clean frames");

    // R2: parity
    wlen = 2'd3; pen = 1'b1; peven = 1'b1;
    expect_char(8'h37); send_frame(8'h37, 0, 0);
    check_flags(4'h0, "R2 good even parity");
    expect_char(8'h37); send_frame(8'h37, 1, 0);
    check_flags(4'h2, "R2 bad even parity");
    clear_flags();
    check_flags(4'h0, "R6 clear flags");
    check_count("R6 count kept by clear");
    peven = 1'b0;
    expect_char(8'h01); send_frame(8'h01, 0, 0);
    check_flags(4'h0, "R2 good odd parity");
    // R4: parity outranks framing
    expect_char(8'h37); send_frame(8'h37, 1, 1);
    check_flags(4'h2, "R4 parity over framing");
    clear_flags();
    drain("R2 drain parity chars");

    // R3: framing
    pen = 1'b0; wlen = 2'd2;
    expect_char(8'h55); send_frame(8'h55, 0, 1);
    check_flags(4'h1, "R3 low stop bit");
    clear_flags();
    wlen = 2'd3; stop2 = 1'b1;
    expect_char(8'h81); send_frame(8'h81, 0, 1);
    check_flags(4'h1, "R3 second stop bit low");
    clear_flags();
    expect_char(8'h7E); send_frame(8'h7E, 0, 0);
    check_flags(4'h0, "R3 two good stop bits");
    drain("R3 drain framing chars");
    stop2 = 1'b0;

    // R4: break under odd parity, line held low afterwards
    pen = 1'b1; peven = 1'b0;
    expect_char(8'h00); send_break(3);
    check_flags(4'h4, "R4 break only flag");
    check_count("R4 single char for held break");
    drain("R4 break data");
    clear_flags();
    pen = 1'b0;

    // R5: overrun with 4-entry FIFO
    for (int i = 0; i < 5; i++) begin
      if (i < 4) expect_char(8'h60 + 8'(i));
      send_frame(8'h60 + 8'(i), 0, 0);
    end
    check_flags(4'h8, "R5 overrun flag");
    check_count("R5 count excludes dropped char");
    drain("R5 drain keeps first four");
    clear_flags();

    // R8: enables
    uen = 1'b0; send_frame(8'hC3, 0, 0);
    check_count("R8 ignored with peripheral off");
    @(negedge clk); check(stat[24] === 1'b1, "R8 FIFO empty peripheral off", stat, 32'h0100_0000);
    uen = 1'b1; ren = 1'b0; send_frame(8'hC3, 0, 1);
    check_count("R8 ignored with receive off");
    check_flags(4'h0, "R8 no flags while off");
    ren = 1'b1;
    expect_char(8'hC3); send_frame(8'hC3, 0, 0);
    check_count("R8 receives after re-enable");
    drain("R8 drain");
    check(to_seen == 0, "R9 no timeout while disabled", to_seen, 0);

    // R9: idle timeout
    toen = 1'b1; tolim = 11'(TLIM);
    expect_char(8'h11); send_frame(8'h11, 0, 0);
    repeat (TLIM * BIT_CLK + 100) @(posedge clk);
    @(negedge clk);
    check(to_seen == 1, "R9 timeout raised", to_seen, 1);
    check((to_cyc - rx_cyc) >= TLIM*BIT_CLK - 4 && (to_cyc - rx_cyc) <= TLIM*BIT_CLK + 4,
          "R9 timeout delay from char", 32'(to_cyc - rx_cyc), 32'(TLIM*BIT_CLK));
    repeat (2 * TLIM * BIT_CLK) @(posedge clk);
    @(negedge clk);
    check(to_seen == 1, "R9 single event per idle period", to_seen, 1);
    drain("R9 drain");

    // R10: read restarts timer
    expect_char(8'h22); send_frame(8'h22, 0, 0);
    expect_char(8'h33); send_frame(8'h33, 0, 0);
    repeat (500) @(posedge clk);
    read_one();
    repeat (TLIM * BIT_CLK + 100) @(posedge clk);
    @(negedge clk);
    check(to_seen == 2, "R10 timeout after read", to_seen, 2);
    check((to_cyc - rd_cyc) >= TLIM*BIT_CLK - 4 && (to_cyc - rd_cyc) <= TLIM*BIT_CLK + 4,
          "R10 delay measured from read", 32'(to_cyc - rd_cyc), 32'(TLIM*BIT_CLK));
    drain("R10 drain");
    repeat (TLIM * BIT_CLK + 500) @(posedge clk);
    @(negedge clk);
    check(to_seen == 2, "R10 no timeout when empty", to_seen, 2);

    // R9: zero limit never fires
    tolim = '0;
    expect_char(8'h44); send_frame(8'h44, 0, 0);
    repeat (2100) @(posedge clk);
    @(negedge clk);
    check(to_seen == 2, "R9 zero limit silent", to_seen, 2);
    drain("R9 drain zero limit");
    check_count("R7 final count");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule